// File: doc/BRIEF.md
# Periodic Interval Tick Timer

This block produces a steady time base for an operating-system scheduler. The system clock passes through a fixed divide-by-16 stage. Each divided tick advances a 20-bit interval count. When a tick finds the count at or above the programmed interval limit, the count returns to zero and one elapsed period is recorded. A separate 12-bit period tally keeps counting while software is busy, so a late handler still learns how many periods went by.

Software programs a configuration word with three fields: the interval limit, a run bit and an interrupt-enable bit. It reads the live interval count and the period tally from the output ports at any time. Observing those ports has no side effect, so they act as a mirror. Pulsing the acknowledge strobe is the destructive read: it clears the tally and the pending flag. The interrupt output is level-sensitive and stays high while a period is pending and interrupts are enabled.

Top module: `pit_tick_timer`

## Requirements
- R1: After synchronous reset the interval count, period tally, pending flag and interrupt are all 0, and nothing counts until run is written as 1.
- R2: While running, the interval count rises by one every 16 clock cycles. The first rise shows 16 cycles after the cycle that wrote run = 1.
- R3: When a divided tick finds the count greater than or equal to the interval limit N, the count becomes 0 and the tally rises by one. The period is therefore 16*(N+1) cycles.
- R4: The pending flag is 1 exactly while the tally is non-zero. The interrupt equals pending AND the interrupt-enable bit, so it stays 0 with the enable bit 0.
- R5: A cycle with the acknowledge strobe high sets the tally to 0 and clears pending on the next edge. If a period completes on that same edge, the tally becomes 1 and pending stays 1.
- R6: Without an acknowledge, completed periods accumulate in the tally, and reading the ports clears nothing.
- R7: The tally saturates at 4095 and does not wrap.
- R8: Writing run = 0 lets the current period finish. The count stops at 0 after its final wrap, that wrap is counted, and no later periods are counted.
- R9: Lowering the limit below the current count while running causes a wrap on the very next divided tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_interval | input | 20 | Interval limit N |
| cfg_run | input | 1 | Run bit |
| cfg_irq_en | input | 1 | Interrupt-enable bit |
| val_rd | input | 1 | Acknowledging read strobe |
| cur_count | output | 20 | Live interval count |
| periods | output | 12 | Elapsed-period tally |
| pending | output | 1 | Period-pending status |
| irq | output | 1 | Level interrupt |

## Verification
A fault in the divider shifts the whole staircase of the interval count, so it shows up within 16 to 32 cycles of enabling. A wrong wrap compare or a wrong tally update shows up at the first period boundary, which is at most 80 cycles in the small configurations that are swept. Acknowledge and saturation faults stay hidden until the exact edge where an acknowledge coincides with a wrap, or until the 4095th period. For that reason the sweep places strobes on boundary edges and drives one run to saturation.

// File: rtl/pit_pkg.sv
// Package: shared definitions for the periodic interval tick timer.
// Assumes: consumers import the run-state encoding from here.
package pit_pkg;
    localparam int unsigned PIT_DIV_DEF   = 16;
    localparam int unsigned PIT_CNT_W_DEF = 20;
    localparam int unsigned PIT_PER_W_DEF = 12;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_t;
endpackage

// File: rtl/pit_prescaler.sv
// Module: fixed clock divider. It emits one-cycle tick pulses every DIV
// cycles while enabled.
// Assumes: DIV >= 1. The counter is held at zero while disabled, so the
// first tick arrives DIV cycles after enable rises.
module pit_prescaler #(
    parameter int unsigned DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    output logic tick
);
    localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] div_q;

    assign tick = enable && (div_q == LAST);

    // Advance the divider phase while enabled, and park it at zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable || tick) div_q <= '0;
        else                           div_q <= div_q + 1'b1;
    end

    generate
        if (DIV > 1) begin : g_rate_chk
            AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick); // R2
        end
    endgenerate
endmodule

// File: rtl/pit_interval.sv
// Module: interval counter. It steps on each tick and wraps to zero when a
// tick finds the count at or above the limit.
// Assumes: tick is a single-cycle pulse and limit may change at any time.
module pit_interval #(
    parameter int unsigned CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);
    assign wrap = tick && (count >= limit);

    // Step or wrap the interval count on each divided tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    count <= '0;
        else if (wrap) count <= '0;
        else if (tick) count <= count + 1'b1;
    end

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (count == '0)); // R3
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wrap) |=> (count == $past(count) + 1'b1)); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(count)); // R2
endmodule

// File: rtl/pit_periods.sv
// Module: elapsed-period tally and pending flag, with acknowledge-on-read.
// Assumes: ack is the destructive read strobe. A wrap on the same edge
// reloads the tally to 1.
module pit_periods #(
    parameter int unsigned PER_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wrap,
    input  logic             ack,
    output logic [PER_W-1:0] periods,
    output logic             pending
);
    localparam logic [PER_W-1:0] PER_MAX = {PER_W{1'b1}};
    localparam logic [PER_W-1:0] PER_ONE = PER_W'(1);

    // Count completed periods, saturating, and clear or reload on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)                          periods <= '0;
        else if (ack)                        periods <= wrap ? PER_ONE : '0;
        else if (wrap && periods != PER_MAX) periods <= periods + 1'b1;
    end

    // Hold the pending flag from a completed period until it is acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n)    pending <= 1'b0;
        else if (ack)  pending <= wrap;
        else if (wrap) pending <= 1'b1;
    end

    AST_PEND_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        pending == (periods != '0)); // R4
    AST_NO_WRAP_OVER: assert property (@(posedge clk) disable iff (!rst_n)
        (periods == PER_MAX && wrap && !ack) |=> (periods == PER_MAX)); // R7
    AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !wrap) |=> (periods == '0 && !pending)); // R5
    AST_ACK_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && wrap) |=> (periods == PER_ONE && pending)); // R5
endmodule

// File: rtl/pit_tick_timer.sv
// Module: top of the periodic interval tick timer. It holds the
// configuration word and the run/drain state, and wires the divider, the
// interval counter and the period tally together.
// Assumes: synchronous active-low reset. Clearing run lets the current
// period complete before counting stops.
module pit_tick_timer
    import pit_pkg::*;
#(
    parameter int unsigned DIV   = PIT_DIV_DEF,
    parameter int unsigned CNT_W = PIT_CNT_W_DEF,
    parameter int unsigned PER_W = PIT_PER_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CNT_W-1:0] cfg_interval,
    input  logic             cfg_run,
    input  logic             cfg_irq_en,
    input  logic             val_rd,
    output logic [CNT_W-1:0] cur_count,
    output logic [PER_W-1:0] periods,
    output logic             pending,
    output logic             irq
);
    logic [CNT_W-1:0] limit_q;
    logic             run_q;
    logic             ien_q;
    run_state_t       state_q;
    logic             run_next;
    logic             tick;
    logic             wrap;

    assign run_next = cfg_we ? cfg_run : run_q;

    // Capture the configuration word on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            limit_q <= '0;
            run_q   <= 1'b0;
            ien_q   <= 1'b0;
        end else if (cfg_we) begin
            limit_q <= cfg_interval;
            run_q   <= cfg_run;
            ien_q   <= cfg_irq_en;
        end
    end

    // Run while enabled, and drop to idle only at the wrap that ends a period.
    always_ff @(posedge clk) begin
        if (!rst_n)        state_q <= ST_IDLE;
        else if (run_next) state_q <= ST_RUN;
        else if (wrap)     state_q <= ST_IDLE;
    end

    pit_prescaler #(.DIV(DIV)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (state_q == ST_RUN),
        .tick   (tick)
    );

    pit_interval #(.CNT_W(CNT_W)) u_ivl (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .limit (limit_q),
        .count (cur_count),
        .wrap  (wrap)
    );

    pit_periods #(.PER_W(PER_W)) u_per (
        .clk     (clk),
        .rst_n   (rst_n),
        .wrap    (wrap),
        .ack     (val_rd),
        .periods (periods),
        .pending (pending)
    );

    assign irq = pending && ien_q;

    AST_IDLE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (cur_count == '0)); // R8
    AST_IDLE_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !tick); // R8
endmodule

// File: tb/tb_pit_tick_timer.sv
module tb_pit_tick_timer;
    localparam int DIV   = 16;
    localparam int PMAX  = 4095;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [19:0] cfg_interval;
    logic        cfg_run;
    logic        cfg_irq_en;
    logic        val_rd;
    logic [19:0] cur_count;
    logic [11:0] periods;
    logic        pending;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    pit_tick_timer dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_interval(cfg_interval),
        .cfg_run(cfg_run), .cfg_irq_en(cfg_irq_en), .val_rd(val_rd),
        .cur_count(cur_count), .periods(periods), .pending(pending), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cfg_we = 1'b0; cfg_interval = '0; cfg_run = 1'b0;
        cfg_irq_en = 1'b0; val_rd = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Called at a negedge; the write takes effect at the next posedge (edge 0).
    task automatic write_cfg(input int n, input bit run, input bit ien);
        cfg_interval = 20'(n); cfg_run = run; cfg_irq_en = ien; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic check_all(input int ec, input int ep, input bit ien, input string tag);
        chk(cur_count == 20'(ec), {tag, " count"}, int'(cur_count), ec);
        chk(periods == 12'(ep), {tag, " periods"}, int'(periods), ep);
        chk(pending == (ep != 0), "R4 pending", int'(pending), int'(ep != 0));
        chk(irq == ((ep != 0) && ien), "R4 irq", int'(irq), int'((ep != 0) && ien));
    endtask

    // Sweep one interval: per-cycle checks, with optional acknowledges that
    // fall both on a wrap edge and away from one.
    task automatic run_sweep(input int n, input bit ien, input int ncyc,
                             input bit acks, input string tag);
        int p;
        int base;
        int ep;
        p = DIV * (n + 1);
        base = 0;
        write_cfg(n, 1'b1, ien);
        for (int k = 0; k < ncyc; k++) begin
            ep = (k / p) - base;
            if (ep > PMAX) ep = PMAX;
            check_all((k / DIV) % (n + 1), ep, ien, tag);
            val_rd = 1'b0;
            if (acks && (((k % (3 * p)) == p - 1) || ((k % (3 * p)) == 2 * p + 5))) begin
                val_rd = 1'b1;
                base = k / p;
            end
            @(negedge clk);
        end
        val_rd = 1'b0;
    endtask

    initial begin
        int ep;
        int ec;
        do_reset();
        // R1: reset state and no counting before run is written
        for (int i = 0; i < 40; i++) begin
            check_all(0, 0, 1'b0, "R1");
            @(negedge clk);
        end

        // R2 R3 R5 R6: sweep small intervals with acknowledges
        for (int n = 0; n <= 4; n++) begin
            do_reset();
            run_sweep(n, 1'b1, 9 * DIV * (n + 1) + 7, 1'b1, "R2 R3 R5 R6");
        end

        // R4: interrupt held low with the enable bit clear
        do_reset();
        run_sweep(3, 1'b0, 200, 1'b0, "R4 R6");

        // R7: saturation of the tally with the shortest interval
        do_reset();
        run_sweep(0, 1'b1, DIV * (PMAX + 3) + 3, 1'b0, "R7");

        // R8: clearing run finishes the current period, then stops
        do_reset();
        write_cfg(2, 1'b1, 1'b1);
        for (int k = 0; k < 61; k++) begin
            check_all((k / DIV) % 3, k / 48, 1'b1, "R8");
            if (k < 60) @(negedge clk);
        end
        write_cfg(2, 1'b0, 1'b1);
        for (int k = 61; k < 220; k++) begin
            ec = (k < 96) ? (k / DIV) % 3 : 0;
            ep = (k < 96) ? k / 48 : 2;
            check_all(ec, ep, 1'b1, "R8");
            @(negedge clk);
        end

        // R9: lowering the limit below the count wraps on the next tick
        do_reset();
        write_cfg(10, 1'b1, 1'b1);
        for (int k = 0; k < 86; k++) begin
            check_all(k / DIV, 0, 1'b1, "R9");
            if (k < 85) @(negedge clk);
        end
        write_cfg(2, 1'b1, 1'b1);
        for (int k = 86; k < 250; k++) begin
            ec = (k < 96) ? 5 : ((k - 96) / DIV) % 3;
            ep = (k < 96) ? 0 : 1 + (k - 96) / 48;
            check_all(ec, ep, 1'b1, "R9");
            @(negedge clk);
        end

        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #1500000;
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule